// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a single-port synchronous memory built for a shared data bus that must change between reads and writes on consecutive clock edges with no idle cycle. A read is flow-through: the address is registered on a rising edge, and the addressed word reaches `q_o` during the same clock period with no output register in the path. A write is late: its address, direction and byte enables are registered on one edge, and its data is taken from `d_i` on the next enabled edge. The block holds that data in a pending-write stage and commits it to the array one enabled edge after that.

A read that hits a word whose data is still pending returns that data through a bypass, lane by lane. Each cycle is a load cycle or an advance cycle. On a load cycle the block decodes a new operation and base address. On an advance cycle it continues the current operation at the next address from a two-bit burst counter, in linear or interleaved order. The clock enable can freeze the whole block. Three chip selects of mixed polarity gate the decode, and the output driver is qualified by an asynchronous output enable. The bidirectional bus is split into `d_i`, `q_o` and `q_oe_o`. The address width, lane count and lane width are parameters.

Top module: `ftlw_sram`

## Requirements
- R1: A write is issued on an enabled edge where `load_ni`=0, the block is selected and `wr_i`=1, or on an advance edge of a write burst. The bus data for it is sampled from `d_i` on the next enabled edge, and from then on reads of that address return it.
- R2: `be_ni` is active low and is sampled with the write address, not with the data. `be_ni[i]`=0 writes bits `8i+7:8i` (lane width 8). A lane whose enable is 1 keeps its old content.
- R3: A read issued on edge k shows the addressed word on `q_o` during the clock period that follows edge k. `q_oe_o` is 1 in that period only while `oe_ni`=0, and `oe_ni` acts without a clock edge.
- R4: An enabled edge with `load_ni`=0 decodes the cycle type (read, write or deselect), loads `addr_i` as the new base and restarts the burst counter at 0.
- R5: An enabled edge with `load_ni`=1 continues the current operation at the next burst address. Only the two low address bits change, and they wrap after four accesses. With counter c and base low bits b, linear order (`order_i`=0) gives (b+c) mod 4 and interleaved order (`order_i`=1) gives b XOR c. `order_i` is sampled on load edges.
- R6: An edge with `cke_ni`=1 is ignored. The operation, burst state, pending write and output all hold, and a pending write waits for the next enabled edge to take its data.
- R7: The block is selected only when `cs0_ni`=0, `cs1_i`=1 and `cs2_ni`=0. Any other load is a deselect: `q_oe_o` stays 0 for that cycle, and a write already in flight still completes.
- R8: A read of an address whose write data is pending returns the pending bytes in the enabled lanes and the array bytes in the other lanes.
- R9: Reads and writes in any order, issued on consecutive edges, all complete correctly with no idle cycle between them.
- R10: During a write cycle `q_oe_o` is 0.
- R11: After reset the block is deselected, with `q_oe_o`=0 and no write pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| load_ni | input | 1 | 0 = load new operation and address, 1 = advance burst |
| wr_i | input | 1 | 1 = write, 0 = read (load cycles) |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| addr_i | input | AW | Word address |
| be_ni | input | NB | Byte write enables, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| d_i | input | NB*LW | Write data from bus |
| q_o | output | NB*LW | Read data to bus |
| q_oe_o | output | 1 | Bus driver enable |

## Verification
Read data and `q_oe_o` are due in the same clock period as the edge that issues the read. Write data is due on `d_i` one enabled edge after its address, and the array holds it one enabled edge after that, so a read on the edge right after the data edge exercises the bypass. The bench drives every input at the falling edge. It then waits through exactly one rising edge and samples the outputs at the next falling edge. Expected words follow from this two-stage write timing. The test of the asynchronous output enable is the one check made without a clock edge.

// File: rtl/ftlw_pkg.sv
package ftlw_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  function automatic logic [1:0] burst_lsb(logic [1:0] base, logic [1:0] cnt, logic ileave);
    return ileave ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/ftlw_burst_seq.sv
module ftlw_burst_seq #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          order_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] nxt_addr_o
);
  import ftlw_pkg::*;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, nxt_cnt;
  logic          ord_q;

  assign nxt_cnt    = cnt_q + 2'd1;
  assign cur_addr_o = {base_q[AW-1:2], burst_lsb(base_q[1:0], cnt_q, ord_q)};
  assign nxt_addr_o = load_i ? addr_i
                             : {base_q[AW-1:2], burst_lsb(base_q[1:0], nxt_cnt, ord_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      ord_q  <= 1'b0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= 2'd0;
        ord_q  <= order_i;
      end else begin
        cnt_q  <= nxt_cnt;
      end
    end
  end

  p_load_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_i |=> cur_addr_o == $past(addr_i));
  p_adv_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q));
  p_hold_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(base_q) && $stable(ord_q));
endmodule

// File: rtl/ftlw_wr_queue.sv
module ftlw_wr_queue #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_word_i,
  output logic          cm_vld_o,
  output logic [AW-1:0] cm_addr_o,
  output logic [NB-1:0] cm_be_o,
  output logic [DW-1:0] cm_data_o,
  output logic [DW-1:0] rd_word_o
);
  // stage a: address/enables waiting for data; stage b: full entry waiting for array
  logic          a_vld, b_vld;
  logic [AW-1:0] a_addr, b_addr;
  logic [NB-1:0] a_be, b_be;
  logic [DW-1:0] b_data;
  logic          hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld  <= 1'b0;
      a_addr <= '0;
      a_be   <= '0;
      b_vld  <= 1'b0;
      b_addr <= '0;
      b_be   <= '0;
      b_data <= '0;
    end else if (en_i) begin
      a_vld  <= issue_i;
      a_addr <= addr_i;
      a_be   <= be_i;
      b_vld  <= a_vld;
      b_addr <= a_addr;
      b_be   <= a_be;
      b_data <= wdata_i;
    end
  end

  assign cm_vld_o  = en_i & b_vld;
  assign cm_addr_o = b_addr;
  assign cm_be_o   = b_be;
  assign cm_data_o = b_data;
  assign hit       = b_vld && (b_addr == rd_addr_i);

  for (genvar l = 0; l < NB; l++) begin : g_byp
    assign rd_word_o[l*LW +: LW] = (hit && b_be[l]) ? b_data[l*LW +: LW]
                                                    : arr_word_i[l*LW +: LW];
  end

  p_addr_queued_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && issue_i |=> a_vld && a_addr == $past(addr_i) && a_be == $past(be_i));
  p_data_late_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && a_vld |=> b_vld && b_data == $past(wdata_i));
  p_hold_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(a_vld) && $stable(b_vld) && $stable(b_data));
endmodule

// File: rtl/ftlw_array.sv
module ftlw_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [NB-1:0] wbe_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) mem[waddr_i] <= wdata_i[l*LW +: LW];
    end

    assign rdata_o[l*LW +: LW] = mem[raddr_i];
  end
endmodule

// File: rtl/ftlw_sram.sv
module ftlw_sram #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 8,
  localparam int DW = NB * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          load_ni,
  input  logic          wr_i,
  input  logic          cs0_ni,
  input  logic          cs1_i,
  input  logic          cs2_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] be_ni,
  input  logic          order_i,
  input  logic          oe_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          q_oe_o
);
  import ftlw_pkg::*;

  logic          en, load, sel, issue;
  op_e           op_q;
  logic [AW-1:0] cur_addr, nxt_addr, cm_addr;
  logic [NB-1:0] cm_be;
  logic [DW-1:0] cm_data, arr_word;
  logic          cm_vld;

  assign en   = ~cke_ni;
  assign load = ~load_ni;
  assign sel  = ~cs0_ni & cs1_i & ~cs2_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          op_q <= OP_IDLE;
    else if (en && load)  op_q <= !sel ? OP_IDLE : (wr_i ? OP_WR : OP_RD);
  end

  assign issue = load ? (sel & wr_i) : (op_q == OP_WR);

  ftlw_burst_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .load_i     (load),
    .addr_i     (addr_i),
    .order_i    (order_i),
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr)
  );

  ftlw_wr_queue #(.AW(AW), .NB(NB), .LW(LW)) u_wq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .issue_i    (issue),
    .addr_i     (nxt_addr),
    .be_i       (~be_ni),
    .wdata_i    (d_i),
    .rd_addr_i  (cur_addr),
    .arr_word_i (arr_word),
    .cm_vld_o   (cm_vld),
    .cm_addr_o  (cm_addr),
    .cm_be_o    (cm_be),
    .cm_data_o  (cm_data),
    .rd_word_o  (q_o)
  );

  ftlw_array #(.AW(AW), .NB(NB), .LW(LW)) u_arr (
    .clk_i   (clk_i),
    .we_i    (cm_vld),
    .waddr_i (cm_addr),
    .wbe_i   (cm_be),
    .wdata_i (cm_data),
    .raddr_i (cur_addr),
    .rdata_o (arr_word)
  );

  assign q_oe_o = (op_q == OP_RD) & ~oe_ni;

  p_desel_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && load && !sel |=> !q_oe_o);
  p_write_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && load && sel && wr_i |=> !q_oe_o);
  p_rd_decode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && load && sel && !wr_i |=> op_q == OP_RD);
  p_hold_op_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(op_q));
  p_oe_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !q_oe_o);
endmodule

// File: tb/sim_ftlw_sram.sv
`timescale 1ns/1ps
module sim_ftlw_sram;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_ni = 1'b0, load_ni = 1'b1, wr_i = 1'b0;
  logic cs0_ni = 1'b0, cs1_i = 1'b1, cs2_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] be_ni = '1;
  logic order_i = 1'b0, oe_ni = 1'b0;
  logic [DW-1:0] d_i = '0;
  logic [DW-1:0] q_o;
  logic q_oe_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  ftlw_sram #(.AW(AW), .NB(NB), .LW(8)) u0 (.*);

  typedef struct packed {
    logic          ld_n;
    logic          sel;
    logic          wr;
    logic [7:0]    a;
    logic [3:0]    ben;
    logic [31:0]   d;
    logic          chk;
    logic          eoe;
    logic [31:0]   eq;
  } vec_t;

  // one row per clock; d is bus data for the write issued on the previous row
  localparam vec_t VT [14] = '{
    '{1'b0,1'b1,1'b1,8'h10,4'h0,32'h0,        1'b0,1'b0,32'h0},
    '{1'b0,1'b1,1'b1,8'h11,4'h0,32'h11111111, 1'b1,1'b0,32'h0},         // R10
    '{1'b0,1'b1,1'b0,8'h10,4'hF,32'h22222222, 1'b1,1'b1,32'h11111111},  // R1 R3
    '{1'b0,1'b1,1'b0,8'h11,4'hF,32'h0,        1'b1,1'b1,32'h22222222},  // R1
    '{1'b0,1'b1,1'b1,8'h10,4'hE,32'h0,        1'b1,1'b0,32'h0},         // R9
    '{1'b0,1'b1,1'b0,8'h10,4'hF,32'h000000AA, 1'b1,1'b1,32'h111111AA},  // R8 R2
    '{1'b0,1'b1,1'b1,8'h12,4'h0,32'h0,        1'b1,1'b0,32'h0},         // R9
    '{1'b0,1'b1,1'b0,8'h12,4'hF,32'hCAFEF00D, 1'b1,1'b1,32'hCAFEF00D},  // R8
    '{1'b0,1'b0,1'b0,8'h12,4'hF,32'h0,        1'b1,1'b0,32'h0},         // R7
    '{1'b0,1'b1,1'b0,8'h12,4'hF,32'h0,        1'b1,1'b1,32'hCAFEF00D},  // R7
    '{1'b0,1'b1,1'b1,8'h11,4'h7,32'h0,        1'b0,1'b0,32'h0},
    '{1'b0,1'b1,1'b1,8'h11,4'hB,32'hAB000000, 1'b0,1'b0,32'h0},
    '{1'b0,1'b1,1'b0,8'h11,4'hF,32'h00CD0000, 1'b1,1'b1,32'hABCD2222},  // R2 R8
    '{1'b0,1'b1,1'b0,8'h11,4'hF,32'h0,        1'b1,1'b1,32'hABCD2222}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, return at next falling edge
  task automatic cyc(input logic ld_n, input logic ck_n, input logic c0, input logic c1,
                     input logic c2, input logic wr, input logic [7:0] a,
                     input logic [3:0] ben, input logic [31:0] d, input logic ord);
    load_ni = ld_n; cke_ni = ck_n; cs0_ni = c0; cs1_i = c1; cs2_ni = c2;
    wr_i = wr; addr_i = a; be_ni = ben; d_i = d; order_i = ord;
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] bw(input int x);
    return 32'hB0000020 + x;
  endfunction

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 oe in reset", {31'd0, q_oe_o}, 32'd0);
    rst_ni = 1'b1;
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R11 idle after reset", {31'd0, q_oe_o}, 32'd0);

    for (int i = 0; i < 14; i++) begin
      cyc(VT[i].ld_n, 0, 0, VT[i].sel, 0, VT[i].wr, VT[i].a, VT[i].ben, VT[i].d, 0);
      if (VT[i].chk) begin
        chk($sformatf("R9 row%0d oe", i), {31'd0, q_oe_o}, {31'd0, VT[i].eoe});
        if (VT[i].eoe) chk($sformatf("R9 row%0d q", i), q_o, VT[i].eq);
      end
    end

    // R5 linear write burst from 0x21: 21,22,23,20
    cyc(0, 0, 0, 1, 0, 1, 8'h21, 4'h0, 0, 0);
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 4'h0, bw(1), 0);
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 4'h0, bw(2), 0);
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 4'h0, bw(3), 0);
    cyc(0, 0, 0, 1, 0, 0, 8'h22, 4'hF, bw(0), 0);
    chk("R5 lin c0", q_o, bw(2));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 lin c1", q_o, bw(3));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 lin c2 wrap", q_o, bw(0));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 lin c3", q_o, bw(1));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 lin back to base", q_o, bw(2));

    // R5 interleaved read from 0x21: 21,20,23,22
    cyc(0, 0, 0, 1, 0, 0, 8'h21, 4'hF, 0, 1);
    chk("R5 il c0", q_o, bw(1));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 il c1", q_o, bw(0));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 il c2", q_o, bw(3));
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 4'hF, 0, 0);
    chk("R5 il c3", q_o, bw(2));

    // R6 clock enable freezes read and pending write
    cyc(0, 0, 0, 1, 0, 0, 8'h20, 4'hF, 0, 0);
    chk("R4 load read", q_o, bw(0));
    cyc(0, 1, 0, 1, 0, 0, 8'h23, 4'hF, 0, 0);
    chk("R6 held q", q_o, bw(0));
    chk("R6 held oe", {31'd0, q_oe_o}, 32'd1);
    cyc(0, 0, 0, 1, 0, 1, 8'h30, 4'h0, 0, 0);
    cyc(0, 1, 0, 1, 0, 0, 8'h23, 4'hF, 32'hDEADDEAD, 0);
    chk("R6 write held oe", {31'd0, q_oe_o}, 32'd0);
    cyc(0, 0, 0, 1, 0, 0, 8'h30, 4'hF, 32'h600DDA7A, 0);
    chk("R6 data after stall", q_o, 32'h600DDA7A);

    // R7 each select in the wrong state deselects
    cyc(0, 0, 1, 1, 0, 0, 8'h30, 4'hF, 0, 0);
    chk("R7 cs0 high", {31'd0, q_oe_o}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 8'h30, 4'hF, 0, 0);
    chk("R7 cs1 low", {31'd0, q_oe_o}, 32'd0);
    cyc(0, 0, 0, 1, 1, 0, 8'h30, 4'hF, 0, 0);
    chk("R7 cs2 high", {31'd0, q_oe_o}, 32'd0);
    cyc(0, 0, 0, 1, 0, 0, 8'h30, 4'hF, 0, 0);
    chk("R7 reselect", q_o, 32'h600DDA7A);

    // R3 asynchronous output enable
    #1 oe_ni = 1'b1;
    #0.5 chk("R3 oe off async", {31'd0, q_oe_o}, 32'd0);
    oe_ni = 1'b0;
    #0.5 chk("R3 oe on async", {31'd0, q_oe_o}, 32'd1);
    @(negedge clk_i);

    // R7 write in flight completes across a deselect
    cyc(0, 0, 0, 1, 0, 1, 8'h40, 4'h0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 8'h40, 4'hF, 32'h0BADF00D, 0);
    chk("R7 desel oe", {31'd0, q_oe_o}, 32'd0);
    cyc(0, 0, 0, 1, 0, 0, 8'h40, 4'hF, 0, 0);
    chk("R7 write done", q_o, 32'h0BADF00D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule